// File: doc/BRIEF.md
# Sub-vector pack/unpack index sequencer

This block generates the element offsets for a vector move whose elements are grouped into sub-vectors of up to four lanes. After each accepted step request it emits one source offset and one destination offset. The two offsets always belong to the same iteration of a shared loop. The outer loop of that iteration runs over vector index `i`, and the inner loop runs over lane `j`.

Each side has its own ordering mode, chosen independently of the other:
- The interleaved ordering addresses element `i*S + j`, where `S` is the sub-vector length.
- The lane-plane ordering addresses element `i + VL*j`.

A source side in lane-plane ordering gathers separate lane planes into packed sub-vectors. A destination side in lane-plane ordering scatters packed sub-vectors into lane planes. With both sides in the same ordering, the move is a plain copy.

A start pulse captures the vector length, the sub-vector length and the two ordering selects, and clears both walkers. The controller then accepts step requests until the sequence of `VL*S` pairs is complete. It flags the final pair with a done strobe. Neither walker multiplies: each walker keeps lane and row counters and a running offset, which it moves by 1, `S` or `VL`.

Top module: `subvec_seq_top`

## Requirements
- R1: After reset, `valid_o` and `done_o` are 0. A `step_i` before any `start_i` produces no pair.
- R2: With its ordering select at 0, a side emits offset `i*S + j` for iteration (i, j). Iterations are ordered with `i` outer (0..VL-1) and `j` inner (0..S-1), so this side counts 0, 1, 2, ... upward.
- R3: With its ordering select at 1, a side emits offset `i + VL*j` for the same iteration (i, j).
- R4: `pack_i` = 1 selects ordering 1 for the source side. `unpack_i` = 1 selects ordering 1 for the destination side. Each select affects only its own side, and both may be 1 together.
- R5: When both sides use the same ordering, `src_off_o` equals `dst_off_o` on every pair.
- R6: A sequence yields exactly `VL*S` pairs. `done_o` is 1 in the cycle that presents the last pair and is 0 with every other pair.
- R7: A pair appears on the outputs (`valid_o` = 1) in the cycle after each cycle in which `step_i` = 1, a sequence is running, and `start_i` = 0. It appears in no other cycle.
- R8: A `step_i` after the last pair produces no pair and no `done_o` until the next `start_i`.
- R9: `vl_i`, `svl_i`, `pack_i` and `unpack_i` are sampled only in a cycle with `start_i` = 1. Changes to them while a sequence runs do not alter its offsets.
- R10: A start with `vl_i` = 0 gives `done_o` = 1 and `valid_o` = 0 in the following cycle, and then no pairs.
- R11: `svl_i` holds the lane count `S` as an unsigned number: 1 to 4 are used as given, 0 is taken as 1, and 5 to 7 are taken as 4. With `S` = 1 both orderings give offset `i`.
- R12: A `start_i` during a running sequence restarts from the first pair with the new configuration. A `step_i` in the same cycle as `start_i` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture configuration and begin a sequence |
| vl_i | input | VL_W (7) | Vector length, 0 to VL_MAX |
| svl_i | input | 3 | Sub-vector lane count (see R11) |
| pack_i | input | 1 | Source side uses lane-plane ordering |
| unpack_i | input | 1 | Destination side uses lane-plane ordering |
| step_i | input | 1 | Request the next offset pair |
| valid_o | output | 1 | A pair is presented this cycle |
| src_off_o | output | OFF_W (8) | Source element offset |
| dst_off_o | output | OFF_W (8) | Destination element offset |
| done_o | output | 1 | Last pair of the sequence, or empty sequence |

## Verification
The main function is tried with every combination of the two ordering selects, over several vector and lane lengths:
- Pack only and unpack only show that each select steers only its own side.
- Both selects or neither shows that the two walkers stay in lockstep and produce matching offsets.
- Non-square shapes (VL differing from S, VL up to 64 with four lanes) separate a stride of `VL` from a stride of `S`. On a square shape the two strides would be indistinguishable.
- Lane codes 0, 1 and 7 expose the clamping rule. Lane count 1 shows that lane-plane ordering collapses to the identity.

Sequences are also run with idle gaps between steps, with configuration inputs changing mid-run, with a restart in the middle of a run, and with a zero vector length. These show that pairs follow only accepted steps and that the captured configuration alone governs the walk.

// File: rtl/subvec_seq_pkg.sv
package subvec_seq_pkg;

  localparam int LANE_W    = 3;
  localparam int MAX_LANES = 4;

  typedef enum logic {
    WALK_ROW = 1'b0,  // interleaved: i*S + j
    WALK_COL = 1'b1   // lane-plane:  i + VL*j
  } walk_mode_e;

  // map raw lane code onto the legal range 1..MAX_LANES
  function automatic logic [LANE_W-1:0] clamp_lanes(input logic [LANE_W-1:0] raw);
    if (raw == '0)
      return LANE_W'(1);
    else if (int'(raw) > MAX_LANES)
      return LANE_W'(MAX_LANES);
    else
      return raw;
  endfunction

endpackage

// File: rtl/subvec_walker.sv
module subvec_walker
  import subvec_seq_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int OFF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  walk_mode_e        mode,
  input  logic [VL_W-1:0]   vl,
  input  logic [LANE_W-1:0] lanes,
  output logic [OFF_W-1:0]  off
);

  logic [VL_W-1:0]   row_q;
  logic [LANE_W-1:0] lane_q;
  logic [OFF_W-1:0]  base_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  inner_stride;
  logic [OFF_W-1:0]  outer_stride;
  logic [OFF_W-1:0]  base_next;
  logic              lane_wrap;

  always_comb begin
    if (mode == WALK_COL) begin
      inner_stride = OFF_W'(vl);
      outer_stride = OFF_W'(1);
    end else begin
      inner_stride = OFF_W'(1);
      outer_stride = OFF_W'(lanes);
    end
    base_next = base_q + outer_stride;
    lane_wrap = (lane_q == lanes - LANE_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row_q  <= '0;
      lane_q <= '0;
      base_q <= '0;
      off_q  <= '0;
    end else if (adv) begin
      if (lane_wrap) begin
        lane_q <= '0;
        row_q  <= row_q + VL_W'(1);
        base_q <= base_next;
        off_q  <= base_next;
      end else begin
        lane_q <= lane_q + LANE_W'(1);
        off_q  <= off_q + inner_stride;
      end
    end
  end

  assign off = off_q;

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && mode == WALK_ROW) |=> off_q == OFF_W'(int'($past(off_q)) + 1));

  // R3
  col_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == WALK_COL) |->
      int'(off_q) == int'(row_q) + int'(vl) * int'(lane_q));

  // R6
  off_bound_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> int'(off_q) < int'(vl) * int'(lanes));

endmodule

// File: rtl/subvec_ctrl.sv
module subvec_ctrl
  import subvec_seq_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [LANE_W-1:0] lanes_in,
  input  logic              pack_in,
  input  logic              unpack_in,
  output logic [VL_W-1:0]   vl_q,
  output logic [LANE_W-1:0] lanes_q,
  output walk_mode_e        src_mode,
  output walk_mode_e        dst_mode,
  output logic              clr,
  output logic              adv,
  output logic              last,
  output logic              empty_start
);

  logic [LANE_W-1:0] lanes_eff;
  logic [CNT_W-1:0]  total_in;
  logic [CNT_W-1:0]  total_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              running_q;

  always_comb begin
    lanes_eff   = clamp_lanes(lanes_in);
    total_in    = CNT_W'(vl_in) * CNT_W'(lanes_eff);
    clr         = start;
    adv         = running_q && step && !start;
    last        = adv && (cnt_q == total_q - CNT_W'(1));
    empty_start = start && (vl_in == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q      <= '0;
      lanes_q   <= LANE_W'(1);
      src_mode  <= WALK_ROW;
      dst_mode  <= WALK_ROW;
      total_q   <= '0;
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (start) begin
      vl_q      <= vl_in;
      lanes_q   <= lanes_eff;
      src_mode  <= pack_in   ? WALK_COL : WALK_ROW;
      dst_mode  <= unpack_in ? WALK_COL : WALK_ROW;
      total_q   <= total_in;
      cnt_q     <= '0;
      running_q <= (vl_in != '0);
    end else if (adv) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last)
        running_q <= 1'b0;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    running_q |-> cnt_q < total_q);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running_q && !start) |=> ($stable(vl_q) && $stable(lanes_q) &&
                              $stable(src_mode) && $stable(dst_mode)));

  // R12
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == '0);

endmodule

// File: rtl/subvec_seq_top.sv
module subvec_seq_top
  import subvec_seq_pkg::*;
#(
  parameter int VL_MAX = 64,
  localparam int VL_W  = $clog2(VL_MAX + 1),
  localparam int OFF_W = $clog2(VL_MAX * MAX_LANES),
  localparam int CNT_W = $clog2(VL_MAX * MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [LANE_W-1:0] svl_i,
  input  logic              pack_i,
  input  logic              unpack_i,
  input  logic              step_i,
  output logic              valid_o,
  output logic [OFF_W-1:0]  src_off_o,
  output logic [OFF_W-1:0]  dst_off_o,
  output logic              done_o
);

  localparam int NUM_SIDES = 2;

  logic [VL_W-1:0]   vl_q;
  logic [LANE_W-1:0] lanes_q;
  walk_mode_e        src_mode;
  walk_mode_e        dst_mode;
  logic              clr;
  logic              adv;
  logic              last;
  logic              empty_start;

  walk_mode_e       side_mode [NUM_SIDES];
  logic [OFF_W-1:0] side_off  [NUM_SIDES];

  subvec_ctrl #(
    .VL_W  (VL_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start_i),
    .step        (step_i),
    .vl_in       (vl_i),
    .lanes_in    (svl_i),
    .pack_in     (pack_i),
    .unpack_in   (unpack_i),
    .vl_q        (vl_q),
    .lanes_q     (lanes_q),
    .src_mode    (src_mode),
    .dst_mode    (dst_mode),
    .clr         (clr),
    .adv         (adv),
    .last        (last),
    .empty_start (empty_start)
  );

  assign side_mode[0] = src_mode;
  assign side_mode[1] = dst_mode;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    subvec_walker #(
      .VL_W  (VL_W),
      .OFF_W (OFF_W)
    ) u_walk (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .adv   (adv),
      .mode  (side_mode[g]),
      .vl    (vl_q),
      .lanes (lanes_q),
      .off   (side_off[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      done_o    <= 1'b0;
      src_off_o <= '0;
      dst_off_o <= '0;
    end else begin
      valid_o <= adv;
      done_o  <= last || empty_start;
      if (adv) begin
        src_off_o <= side_off[0];
        dst_off_o <= side_off[1];
      end
    end
  end

  // R5
  same_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && src_mode == dst_mode) |-> src_off_o == dst_off_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !valid_o);

  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(step_i) && !$past(start_i)));

  // R10
  empty_run_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && vl_i == '0) |=> (done_o && !valid_o));

endmodule

// File: tb/subvec_seq_top_tb_top.sv
module subvec_seq_top_tb_top;

  localparam int VL_MAX = 64;
  localparam int VL_W   = $clog2(VL_MAX + 1);
  localparam int OFF_W  = $clog2(VL_MAX * 4);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [VL_W-1:0]  vl_i = '0;
  logic [2:0]       svl_i = 3'd1;
  logic             pack_i = 1'b0;
  logic             unpack_i = 1'b0;
  logic             step_i = 1'b0;
  logic             valid_o;
  logic [OFF_W-1:0] src_off_o;
  logic [OFF_W-1:0] dst_off_o;
  logic             done_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  subvec_seq_top #(.VL_MAX(VL_MAX)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .svl_i     (svl_i),
    .pack_i    (pack_i),
    .unpack_i  (unpack_i),
    .step_i    (step_i),
    .valid_o   (valid_o),
    .src_off_o (src_off_o),
    .dst_off_o (dst_off_o),
    .done_o    (done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      miscompares++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input int raw);
    if (raw == 0) return 1;
    if (raw > 4) return 4;
    return raw;
  endfunction

  // expected offset of step k for one side
  function automatic int exp_off(input bit col, input int k, input int vl, input int s);
    int i = k / s;
    int j = k % s;
    return col ? (i + vl * j) : (i * s + j);
  endfunction

  // called at a negedge; leaves at a negedge
  task automatic do_start(input int vl, input int s, input bit p, input bit u);
    start_i  = 1'b1;
    vl_i     = VL_W'(vl);
    svl_i    = 3'(s);
    pack_i   = p;
    unpack_i = u;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic step_once();
    step_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic check_pair(input int k, input int n, input int vl, input int s,
                            input bit p, input bit u);
    chk("R7 valid", int'(valid_o), 1);
    chk("R2/R3 R4 src offset", int'(src_off_o), exp_off(p, k, vl, s));
    chk("R2/R3 R4 dst offset", int'(dst_off_o), exp_off(u, k, vl, s));
    if (p == u) chk("R5 equal offsets", int'(src_off_o), int'(dst_off_o));
    chk("R6 done", int'(done_o), (k == n - 1) ? 1 : 0);
  endtask

  task automatic walk_all(input int vl, input int s, input bit p, input bit u);
    int n = vl * s;
    for (int k = 0; k < n; k++) begin
      step_once();
      check_pair(k, n, vl, s, p, u);
    end
  endtask

  task automatic after_done_check();
    step_once();
    chk("R8 no pair after done", int'(valid_o), 0);
    chk("R8 no done after done", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    step_once();
    chk("R1 step before start", int'(valid_o), 0);
  endtask

  task automatic t_seq(input int vl, input int raw_s, input bit p, input bit u);
    int s = lanes_of(raw_s);
    do_start(vl, raw_s, p, u);
    walk_all(vl, s, p, u);
    after_done_check();
  endtask

  task automatic t_gaps();
    int n = 4 * 3;
    do_start(4, 3, 1'b0, 1'b1);
    for (int k = 0; k < n; k++) begin
      step_once();
      check_pair(k, n, 4, 3, 1'b0, 1'b1);
      @(negedge clk);
      chk("R7 idle cycle no pair", int'(valid_o), 0);
    end
  endtask

  task automatic t_cfg_change();
    int n = 5 * 2;
    do_start(5, 2, 1'b1, 1'b0);
    vl_i = VL_W'(3); svl_i = 3'd4; pack_i = 1'b0; unpack_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      step_once();
      check_pair(k, n, 5, 2, 1'b1, 1'b0);  // R9
      if (k == 4) begin vl_i = VL_W'(9); svl_i = 3'd3; end
    end
    after_done_check();
  endtask

  task automatic t_zero();
    do_start(0, 3, 1'b1, 1'b0);
    chk("R10 empty done", int'(done_o), 1);
    chk("R10 empty no pair", int'(valid_o), 0);
    @(negedge clk);
    chk("R10 done single cycle", int'(done_o), 0);
    step_once();
    chk("R10 no pair after empty", int'(valid_o), 0);
  endtask

  task automatic t_restart();
    do_start(5, 3, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step_once();
      check_pair(k, 15, 5, 3, 1'b1, 1'b0);
    end
    step_i = 1'b1;
    do_start(4, 2, 1'b0, 1'b1);
    step_i = 1'b0;
    chk("R12 step with start ignored", int'(valid_o), 0);
    walk_all(4, 2, 1'b0, 1'b1);  // R12 restarts from first pair
    after_done_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq(4, 4, 1'b0, 1'b0);   // R2 plain copy
    t_seq(5, 3, 1'b1, 1'b0);   // R3 R4 pack
    t_seq(3, 4, 1'b0, 1'b1);   // R3 R4 unpack
    t_seq(6, 2, 1'b1, 1'b1);   // R4 R5 both
    t_seq(64, 4, 1'b1, 1'b0);  // R6 longest
    t_seq(1, 2, 1'b0, 1'b1);   // R6 single vector
    t_seq(7, 1, 1'b1, 1'b1);   // R11 one lane
    t_seq(3, 0, 1'b1, 1'b0);   // R11 code 0 -> 1 lane
    t_seq(3, 7, 1'b1, 1'b0);   // R11 code 7 -> 4 lanes
    t_seq(2, 3, 1'b0, 1'b1);   // R11 three lanes
    t_gaps();
    t_cfg_change();
    t_zero();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule